// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a peripheral has left stuck. A peripheral can hang while it pulls SDA low, for example mid-ACK or partway through a read byte. After a recover request the sequencer first checks whether SCL is being stretched and waits a bounded number of polls for the stretch to end. It then clocks SCL by hand, checking SDA before every pulse and stopping as soon as SDA reads high. It finishes with a STOP condition that returns the bus to idle.

Both lines are driven open-drain. Each output is only a pull-low enable, and the pad resolves the line level that comes back on the inputs. Every timed step of the bit-bang lasts one half-period of `half_period + 1` system clocks. The result is reported as a one-cycle `done` pulse with a 2-bit code. The code separates success, a clock that stays low and data that stays low. Line inputs are assumed to be synchronous to `clk` already. `half_period` is assumed stable while `busy` is high.

Top module: `i2c_unstick_seq`

## Requirements
- R1: After reset and whenever idle, `busy`, `done`, `scl_oe` and `sda_oe` are all low.
- R2: An accepted `start` raises `busy` on the next cycle, and `busy` stays high up to and including the single cycle in which `done` is high. `status` is valid in that cycle, and `done` never lasts two cycles.
- R3: If SCL reads low when recovery begins, SCL is polled once per half-period for up to STRETCH_TRIES further polls. If it reads high at any poll, recovery continues with the data phase.
- R4: If SCL is still low at the last poll, recovery ends with status 2'b01. Neither line is ever pulled low in that run, and no STOP is made.
- R5: SDA is sampled before each SCL pulse, and pulsing stops as soon as it reads high. At most MAX_PULSES (default 9) pulses are generated.
- R6: If SDA is still low after MAX_PULSES pulses, the status is 2'b10, and the STOP sequence is still driven.
- R7: The STOP sequence pulls SCL low, then pulls SDA low, then releases SCL, then releases SDA while SCL is released. A recovery that frees SDA ends with status 2'b00.
- R8: Each timed step lasts `half_period + 1` cycles. With no clock stretch and P pulses, `busy` is high for 3 + P + 2·P·(half_period+1) + 4·(half_period+1) cycles.
- R9: SDA is only ever pulled low while SCL has been pulled low for at least one cycle, so recovery never produces a START condition.
- R10: A `start` seen while `busy` is high is ignored and does not change the outcome of the running recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Recover request, accepted only when idle |
| half_period | input | HALF_W | Half-period length minus one, in system clocks |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| busy | output | 1 | Recovery in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 freed, 01 clock held low, 10 data held low |

## Verification
The bound checker checks these rules on every cycle:
- The lines stay quiet while idle.
- `done` is a single-cycle pulse inside `busy`.
- SDA is pulled low only under a low SCL, and is released only with SCL released.
- No run exceeds its pulse budget.
- A clock-held-low failure never drove either line.

Some behaviour only the bench scenarios can show. An open-drain peripheral model holds SCL for a chosen time and keeps SDA low for a chosen number of clocks. Against that model the bench checks the status code, the exact pulse count, that a real STOP appears on the lines, the busy duration against the half-period, and that a repeated request mid-run changes nothing.

// File: rtl/i2c_unstick_pkg.sv
// Shared types for the I2C bus recovery sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package i2c_unstick_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHK_SCL,
        ST_WAIT,
        ST_CHK_SDA,
        ST_LO,
        ST_HI,
        ST_STOP_A,
        ST_STOP_B,
        ST_STOP_C,
        ST_STOP_D,
        ST_FIN
    } seq_state_e;

    typedef enum logic [1:0] {
        RC_OK      = 2'b00,
        RC_SCL_LOW = 2'b01,
        RC_SDA_LOW = 2'b10
    } rec_code_e;

endpackage

// File: rtl/unstick_halfper.sv
// Half-period timer: raises tick when the count reaches limit, then wraps.
// Assumes: restart is pulsed on every state change so a timed phase starts at 0.
module unstick_halfper #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [HALF_W-1:0] limit,
    output logic              tick
);
    logic [HALF_W-1:0] cnt_q;

    assign tick = (cnt_q == limit);

    // Count system clocks inside the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (restart || tick) cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/unstick_cnt.sv
// Saturating event counter that flags when it holds LAST.
// Assumes: clr has priority over inc.
module unstick_cnt #(
    parameter int LAST = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int W = (LAST < 1) ? 1 : $clog2(LAST + 1);

    logic [W-1:0] cnt_q;

    assign at_last = (cnt_q == W'(LAST));

    // Track events since the last clear, stopping at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (clr)               cnt_q <= '0;
        else if (inc && !at_last)   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/i2c_unstick_seq.sv
// I2C bus recovery sequencer (controller side).
// Waits out a bounded SCL stretch, bit-bangs up to MAX_PULSES SCL pulses
// until SDA is released, then drives a STOP. Outputs are pull-low enables.
// Assumes: scl_in/sda_in are synchronous to clk; half_period stable while busy.
module i2c_unstick_seq
    import i2c_unstick_pkg::*;
#(
    parameter int HALF_W        = 8,
    parameter int STRETCH_TRIES = 8,
    parameter int MAX_PULSES    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [HALF_W-1:0] half_period,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status
);
    localparam int TRY_LAST = (STRETCH_TRIES < 1) ? 0 : STRETCH_TRIES - 1;

    seq_state_e state_q, state_d;
    rec_code_e  code_q, code_d;
    logic       tick;
    logic       try_clr, try_inc, try_last;
    logic       pls_clr, pls_inc, pls_last;

    unstick_halfper #(.HALF_W(HALF_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .limit   (half_period),
        .tick    (tick)
    );

    unstick_cnt #(.LAST(TRY_LAST)) u_tries (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (try_clr),
        .inc     (try_inc),
        .at_last (try_last)
    );

    unstick_cnt #(.LAST(MAX_PULSES)) u_pulses (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pls_clr),
        .inc     (pls_inc),
        .at_last (pls_last)
    );

    // Next-state and result-code decision for the recovery sequence.
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        try_clr = 1'b0;
        try_inc = 1'b0;
        pls_clr = 1'b0;
        pls_inc = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start) begin
                state_d = ST_CHK_SCL;
                code_d  = RC_OK;
                try_clr = 1'b1;
                pls_clr = 1'b1;
            end
            ST_CHK_SCL: state_d = scl_in ? ST_CHK_SDA : ST_WAIT;
            ST_WAIT: if (tick) begin
                if (scl_in) begin
                    state_d = ST_CHK_SDA;
                end else if (try_last) begin
                    state_d = ST_FIN;
                    code_d  = RC_SCL_LOW;
                end else begin
                    try_inc = 1'b1;
                end
            end
            ST_CHK_SDA: begin
                if (sda_in) begin
                    state_d = ST_STOP_A;
                end else if (pls_last) begin
                    state_d = ST_STOP_A;
                    code_d  = RC_SDA_LOW;
                end else begin
                    state_d = ST_LO;
                end
            end
            ST_LO:     if (tick) state_d = ST_HI;
            ST_HI:     if (tick) begin
                state_d = ST_CHK_SDA;
                pls_inc = 1'b1;
            end
            ST_STOP_A: if (tick) state_d = ST_STOP_B;
            ST_STOP_B: if (tick) state_d = ST_STOP_C;
            ST_STOP_C: if (tick) state_d = ST_STOP_D;
            ST_STOP_D: if (tick) state_d = ST_FIN;
            ST_FIN:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State and result-code registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= RC_OK;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    // Open-drain pull-low enables decoded from the registered state.
    always_comb begin
        scl_oe = (state_q == ST_LO) || (state_q == ST_STOP_A) || (state_q == ST_STOP_B);
        sda_oe = (state_q == ST_STOP_B) || (state_q == ST_STOP_C);
    end

    assign busy   = (state_q != ST_IDLE);
    assign done   = (state_q == ST_FIN);
    assign status = code_q;
endmodule

// File: rtl/i2c_unstick_seq_chk.sv
// Protocol checker for the recovery sequencer, bound to its top module.
// Assumes: observes ports only; keeps its own per-run bookkeeping.
module i2c_unstick_seq_chk #(
    parameter int MAX_PULSES = 9
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       busy,
    input logic       done,
    input logic [1:0] status
);
    logic       prev_scl;
    logic       drove;
    logic [7:0] falls;

    // Per-run record of SCL pull-downs and of any line driving.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_scl <= 1'b0;
            drove    <= 1'b0;
            falls    <= '0;
        end else begin
            prev_scl <= scl_oe;
            drove    <= busy ? (drove | scl_oe | sda_oe) : 1'b0;
            if (!busy)                  falls <= '0;
            else if (scl_oe && !prev_scl) falls <= falls + 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    p_clk_fail_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'b01) |-> !drove);
    p_pulse_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        falls <= 8'(MAX_PULSES + 1));
    p_code_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status != 2'b11));
    p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_oe);
    p_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> (scl_oe && $past(scl_oe)));
endmodule

bind i2c_unstick_seq i2c_unstick_seq_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe),
    .busy   (busy),
    .done   (done),
    .status (status)
);

// File: tb/i2c_unstick_seq_tb.sv
// Bench for the recovery sequencer: open-drain peripheral model, directed
// corners and seeded random scenarios, checked against computed outcomes.
module i2c_unstick_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TRIES      = 8;
    localparam int MAXP       = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] half_period = 8'd0;
    logic       scl_in, sda_in, scl_oe, sda_oe, busy, done;
    logic [1:0] status;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    // Peripheral model state
    int  cyc = 0;
    int  scl_free_at = 0;
    bit  scl_forever = 1'b0;
    int  nfall = 0;
    int  fall_base = 0;
    int  rel_pulses = 0;
    logic prev_oe = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count cycles and controller SCL releases seen by the peripheral.
    always @(posedge clk) begin
        cyc     <= cyc + 1;
        prev_oe <= scl_oe;
        if (prev_oe && !scl_oe) nfall <= nfall + 1;
    end

    assign scl_in = !scl_oe && !(scl_forever || (cyc < scl_free_at));
    assign sda_in = !sda_oe && !((nfall - fall_base) < rel_pulses);

    i2c_unstick_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .half_period(half_period),
        .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .busy(busy), .done(done), .status(status)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input bit forever_low, input int r);
        if (forever_low) return 1;
        return (r <= MAXP) ? 0 : 2;
    endfunction

    function automatic int exp_pulls(input bit forever_low, input int r);
        if (forever_low) return 0;
        return ((r < MAXP) ? r : MAXP) + 1;
    endfunction

    function automatic int exp_busy(input int hp, input int r);
        int p = (r < MAXP) ? r : MAXP;
        int h = hp + 1;
        return 3 + p + 2 * p * h + 4 * h;
    endfunction

    task automatic run(input int hp, input int d, input bit forever_low, input int r);
        int  nbusy = 0, nscl = 0, nsda = 0;
        bit  got = 1'b0, stop_seen = 1'b0;
        logic ps = 1'b0, pd = 1'b0, pl = 1'b1;
        @(negedge clk);
        half_period = 8'(hp);
        scl_forever = forever_low;
        scl_free_at = cyc + d;
        fall_base   = nfall;
        rel_pulses  = r;
        start       = 1'b1;
        for (int i = 0; i < 20000 && !got; i++) begin
            @(negedge clk);
            start = (nbusy == 4);  // R10: repeat request while busy
            if (busy) nbusy++;
            if (scl_oe && !ps) nscl++;
            if (sda_oe && !pd) nsda++;
            if (!scl_in) stop_seen = 1'b0;
            else if (!pl && sda_in) stop_seen = 1'b1;
            ps = scl_oe; pd = sda_oe; pl = sda_in;
            got = done;
        end
        start = 1'b0;
        chk(got, "R2 done reached", int'(got), 1);
        chk(int'(status) == exp_code(forever_low, r), "R4/R6/R7 status code",
            int'(status), exp_code(forever_low, r));
        chk(nscl == exp_pulls(forever_low, r), "R5 SCL pull count",
            nscl, exp_pulls(forever_low, r));
        chk(nsda == (forever_low ? 0 : 1), "R9 SDA pull count (R4 when clock stuck)",
            nsda, forever_low ? 0 : 1);
        if (!forever_low && r <= MAXP)
            chk(stop_seen, "R7 STOP on bus", int'(stop_seen), 1);
        if (forever_low)
            chk(!stop_seen, "R4 no STOP after clock failure", int'(stop_seen), 0);
        if (!forever_low && d == 0)
            chk(nbusy == exp_busy(hp, r), "R8 busy cycles", nbusy, exp_busy(hp, r));
        if (!forever_low && d > 0)
            chk(int'(status) != 1, "R3 stretch released", int'(status), exp_code(0, r));
        @(negedge clk);
        chk(!done && !busy, "R2 done single cycle, busy drops", int'({done, busy}), 0);
        chk(!scl_oe && !sda_oe, "R1 idle lines released", int'({scl_oe, sda_oe}), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !scl_oe && !sda_oe, "R1 reset state",
            int'({busy, done, scl_oe, sda_oe}), 0);
        // Directed corners
        run(0, 0, 1'b0, 0);    // bus already free
        run(3, 0, 1'b0, 1);
        run(2, 0, 1'b0, MAXP); // released on the last pulse
        run(1, 0, 1'b0, 10);   // R6 data held low
        run(2, 0, 1'b0, 20);
        run(1, 5, 1'b0, 2);    // R3 short stretch
        run(4, 30, 1'b0, 3);   // R3 long stretch
        run(0, 0, 1'b1, 1);    // R4 clock held low
        run(5, 0, 1'b1, 0);
        // Seeded random mix
        for (int k = 0; k < 24; k++) begin
            int hp = int'($urandom % 8);
            bit fl = (($urandom % 6) == 0);
            int d  = (($urandom % 2) == 0) ? 0 : 1 + int'($urandom % (7 * (hp + 1)));
            int r  = int'($urandom % 12);
            run(hp, d, fl, r);
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule